// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Flags and Timed Flush

This block holds the two byte queues that sit between a register-mapped host and a serial bus engine. The host fills the transmit queue and the engine drains it. The engine fills the receive queue and the host drains it. Each queue has a programmed threshold and drives level flags into the interrupt logic: "nearly empty" on the transmit side, "nearly full" on the receive side, plus empty and full on both. A sticky overrun flag records a host write that landed on a full transmit queue.

Each queue can be flushed on its own. The host pulses a flush control bit, and the matching busy flag then reads as set for a fixed number of cycles. The queue is emptied at the end of that window, and the busy flag clears at the same moment. While its busy flag is set, a queue ignores every access from both sides. Software polls the busy flag until it reads clear.

Both queues use a show-ahead read. The oldest byte is always on the read data output, and a pop or read strobe moves to the next byte.

Top module: `byteq_pair`

## Requirements
- R1: After reset both queues are empty. `tx_empty` and `tx_nearly_empty` are 1. `tx_full`, `rx_full`, `tx_overrun`, `flush_tx_busy` and `flush_rx_busy` are 0. `rx_empty` is 1.
- R2: Bytes leave each queue in the order they entered. The oldest transmit byte is on `eng_tx_data` and the oldest receive byte is on `host_rx_data`. A pop or read strobe sampled on a clock edge moves to the next byte.
- R3: A push or pop sampled on an edge updates the level flags after that edge. Full means DEPTH entries and empty means 0 entries. A push and a pop in the same cycle leave the entry count unchanged.
- R4: The effective threshold of each queue is the smaller of the programmed value and DEPTH/2-1. For DEPTH=16 that is 7.
- R5: `tx_nearly_empty` is 1 exactly while the transmit entry count is less than or equal to the effective transmit threshold.
- R6: `rx_nearly_full` is 1 exactly while the receive entry count is greater than or equal to the effective receive threshold.
- R7: A host write to a full transmit queue is discarded. `tx_overrun` becomes 1 after that edge and stays 1 until a transmit flush completes.
- R8: Reading an empty receive queue returns 0 on `host_rx_data` and moves no pointer. A byte pushed afterwards is the next one read.
- R9: A 1 on a flush input sampled while that queue is idle raises its busy flag for exactly FLUSH_CYCLES (4) cycles. When the busy flag falls, the queue is empty. The other queue is not affected.
- R10: While a queue's busy flag is 1, host and engine accesses to that queue are ignored, and a further flush request on the same queue does not lengthen the window.
- R11: An engine push into a full receive queue is discarded. An engine pop from an empty transmit queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_tx_wr | input | 1 | Host write strobe into the transmit queue |
| host_tx_data | input | 8 | Host write byte |
| host_rx_rd | input | 1 | Host read strobe; advances the receive queue |
| host_rx_data | output | 8 | Oldest receive byte, 0 when empty |
| eng_tx_pop | input | 1 | Engine pop strobe on the transmit queue |
| eng_tx_data | output | 8 | Oldest transmit byte, 0 when empty |
| eng_rx_push | input | 1 | Engine push strobe into the receive queue |
| eng_rx_data | input | 8 | Engine push byte |
| tx_thresh | input | $clog2(DEPTH) | Programmed transmit threshold |
| rx_thresh | input | $clog2(DEPTH) | Programmed receive threshold |
| flush_tx_set | input | 1 | Start a transmit flush |
| flush_rx_set | input | 1 | Start a receive flush |
| flush_tx_busy | output | 1 | Transmit flush in progress |
| flush_rx_busy | output | 1 | Receive flush in progress |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_nearly_empty | output | 1 | Transmit count at or below threshold |
| tx_overrun | output | 1 | Sticky: write to full transmit queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_nearly_full | output | 1 | Receive count at or above threshold |

## Verification
The bench programs thresholds above the legal maximum and watches the nearly flags change at the clamped count. A design that skipped the clamp would switch the flags several entries too late.

It writes into a full transmit queue and then drains all DEPTH bytes. A design that stored the extra byte, or lost the sticky overrun, would show a wrong byte or a cleared flag.

During a flush it issues writes, pushes and a second flush request. A design that let accesses through, or restarted the window, would leave data behind or hold busy for more than four cycles.

It also reads an empty receive queue and issues a push and a pop in the same cycle. A design that moved a pointer on the empty read, or miscounted the simultaneous operations, would return bytes out of order.

// File: rtl/byteq_pkg.sv
package byteq_pkg;

  localparam int CH_TX = 0;
  localparam int CH_RX = 1;
  localparam int N_CH  = 2;

  // Largest threshold a queue of the given depth accepts.
  function automatic int unsigned thr_ceiling(int unsigned depth);
    return depth / 2 - 1;
  endfunction

  // Programmed threshold limited to the legal range.
  function automatic int unsigned thr_effective(int unsigned prog, int unsigned depth);
    return (prog > thr_ceiling(depth)) ? thr_ceiling(depth) : prog;
  endfunction

endpackage

// File: rtl/byteq_fifo.sv
module byteq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head_data,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       empty,
  output logic                       full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/byteq_flush_seq.sv
module byteq_flush_seq #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic done
);
  localparam int SW = $clog2(CYCLES + 1);

  logic [SW-1:0] step;

  assign done = busy && (step == SW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (!busy) begin
      step <= '0;
      if (req) busy <= 1'b1;
    end else if (done) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      step <= step + 1'b1;
    end
  end

endmodule

// File: rtl/byteq_pair.sv
module byteq_pair
  import byteq_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_tx_wr,
  input  logic [7:0]                 host_tx_data,
  input  logic                       host_rx_rd,
  output logic [7:0]                 host_rx_data,
  input  logic                       eng_tx_pop,
  output logic [7:0]                 eng_tx_data,
  input  logic                       eng_rx_push,
  input  logic [7:0]                 eng_rx_data,
  input  logic [$clog2(DEPTH)-1:0]   tx_thresh,
  input  logic [$clog2(DEPTH)-1:0]   rx_thresh,
  input  logic                       flush_tx_set,
  input  logic                       flush_rx_set,
  output logic                       flush_tx_busy,
  output logic                       flush_rx_busy,
  output logic                       tx_empty,
  output logic                       tx_full,
  output logic                       tx_nearly_empty,
  output logic                       tx_overrun,
  output logic                       rx_empty,
  output logic                       rx_full,
  output logic                       rx_nearly_full
);
  localparam int TW = $clog2(DEPTH);
  localparam int CW = TW + 1;

  logic [N_CH-1:0] flush_req, flush_busy, flush_done;
  logic [CW-1:0]   tx_level, rx_level;
  logic [TW-1:0]   tx_thr_eff, rx_thr_eff;

  // Named internal events, visible to the bound checker.
  logic tx_push_acc, tx_pop_acc, rx_push_acc, rx_pop_acc;
  logic tx_ovr_evt;
  logic tx_done, rx_done;

  assign flush_req[CH_TX] = flush_tx_set;
  assign flush_req[CH_RX] = flush_rx_set;

  for (genvar c = 0; c < N_CH; c++) begin : g_flush
    byteq_flush_seq #(.CYCLES(FLUSH_CYCLES)) u_seq (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (flush_req[c]),
      .busy (flush_busy[c]),
      .done (flush_done[c])
    );
  end

  assign flush_tx_busy = flush_busy[CH_TX];
  assign flush_rx_busy = flush_busy[CH_RX];
  assign tx_done       = flush_done[CH_TX];
  assign rx_done       = flush_done[CH_RX];

  assign tx_push_acc = host_tx_wr  & ~flush_tx_busy;
  assign tx_pop_acc  = eng_tx_pop  & ~flush_tx_busy;
  assign rx_push_acc = eng_rx_push & ~flush_rx_busy;
  assign rx_pop_acc  = host_rx_rd  & ~flush_rx_busy;

  byteq_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tx_done),
    .push     (tx_push_acc),
    .push_data(host_tx_data),
    .pop      (tx_pop_acc),
    .head_data(eng_tx_data),
    .level    (tx_level),
    .empty    (tx_empty),
    .full     (tx_full)
  );

  byteq_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (rx_done),
    .push     (rx_push_acc),
    .push_data(eng_rx_data),
    .pop      (rx_pop_acc),
    .head_data(host_rx_data),
    .level    (rx_level),
    .empty    (rx_empty),
    .full     (rx_full)
  );

  assign tx_thr_eff = TW'(thr_effective(32'(tx_thresh), DEPTH));
  assign rx_thr_eff = TW'(thr_effective(32'(rx_thresh), DEPTH));

  assign tx_nearly_empty = (tx_level <= {1'b0, tx_thr_eff});
  assign rx_nearly_full  = (rx_level >= {1'b0, rx_thr_eff});

  assign tx_ovr_evt = tx_push_acc & tx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_overrun <= 1'b0;
    else if (tx_done)    tx_overrun <= 1'b0;
    else if (tx_ovr_evt) tx_overrun <= 1'b1;
  end

endmodule

// File: rtl/byteq_pair_chk.sv
module byteq_pair_chk #(
  parameter int FLUSH_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic host_tx_wr,
  input logic host_rx_rd,
  input logic eng_tx_pop,
  input logic eng_rx_push,
  input logic flush_tx_busy,
  input logic flush_rx_busy,
  input logic tx_empty,
  input logic tx_full,
  input logic tx_nearly_empty,
  input logic tx_overrun,
  input logic rx_empty,
  input logic rx_full,
  input logic rx_nearly_full,
  input logic tx_ovr_evt
);
  logic [7:0] tx_run, rx_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_run <= '0;
      rx_run <= '0;
    end else begin
      tx_run <= flush_tx_busy ? tx_run + 1'b1 : '0;
      rx_run <= flush_rx_busy ? rx_run + 1'b1 : '0;
    end
  end

  a_r9_tx_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_tx_busy) |-> (tx_run == 8'(FLUSH_CYCLES)));
  a_r9_rx_flush_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_rx_busy) |-> (rx_run == 8'(FLUSH_CYCLES)));
  a_r9_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_tx_busy) |-> tx_empty);
  a_r9_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_rx_busy) |-> rx_empty);
  a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovr_evt |=> tx_overrun);
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_wr && !flush_tx_busy && tx_full && !eng_tx_pop) |=> tx_full);
  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && host_rx_rd && !eng_rx_push) |=> rx_empty);
  a_r3_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_empty && tx_full));
  a_r6_full_is_near: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> rx_nearly_full);
  a_r5_empty_is_near: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> tx_nearly_empty);
  a_r10_tx_busy_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_tx_busy && tx_empty) |=> tx_empty);

endmodule

bind byteq_pair byteq_pair_chk #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .host_tx_wr     (host_tx_wr),
  .host_rx_rd     (host_rx_rd),
  .eng_tx_pop     (eng_tx_pop),
  .eng_rx_push    (eng_rx_push),
  .flush_tx_busy  (flush_tx_busy),
  .flush_rx_busy  (flush_rx_busy),
  .tx_empty       (tx_empty),
  .tx_full        (tx_full),
  .tx_nearly_empty(tx_nearly_empty),
  .tx_overrun     (tx_overrun),
  .rx_empty       (rx_empty),
  .rx_full        (rx_full),
  .rx_nearly_full (rx_nearly_full),
  .tx_ovr_evt     (tx_ovr_evt)
);

// File: tb/test_byteq_pair.sv
`timescale 1ns/1ps
module test_byteq_pair;
  localparam int DEPTH = 16;
  localparam int TW    = 4;
  localparam int LIMIT = DEPTH / 2 - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_tx_wr = 0, host_rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0] host_tx_data = 0, eng_rx_data = 0;
  logic [7:0] host_rx_data, eng_tx_data;
  logic [TW-1:0] tx_thresh = 2, rx_thresh = 3;
  logic flush_tx_set = 0, flush_rx_set = 0;
  logic flush_tx_busy, flush_rx_busy;
  logic tx_empty, tx_full, tx_nearly_empty, tx_overrun;
  logic rx_empty, rx_full, rx_nearly_full;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  byteq_pair #(.DEPTH(DEPTH), .FLUSH_CYCLES(4)) i_byteq_pair (.*);

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tx_write(input logic [7:0] b);
    host_tx_wr = 1; host_tx_data = b;
    @(negedge clk);
    host_tx_wr = 0;
  endtask

  task automatic tx_pop_expect(input string tag, input int exp);
    chk(tag, eng_tx_data, exp);
    eng_tx_pop = 1;
    @(negedge clk);
    eng_tx_pop = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    eng_rx_push = 1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_push = 0;
  endtask

  task automatic rx_read_expect(input string tag, input int exp);
    chk(tag, host_rx_data, exp);
    host_rx_rd = 1;
    @(negedge clk);
    host_rx_rd = 0;
  endtask

  task automatic t_reset;
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 tx_full", tx_full, 0);
    chk("R1 tx_nearly_empty", tx_nearly_empty, 1);
    chk("R1 tx_overrun", tx_overrun, 0);
    chk("R1 rx_empty", rx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 rx_nearly_full thr3", rx_nearly_full, 0);
    chk("R1 tx busy", flush_tx_busy, 0);
    chk("R1 rx busy", flush_rx_busy, 0);
  endtask

  task automatic t_tx_order;
    tx_thresh = 2;
    for (int i = 0; i < 5; i++) begin
      tx_write(8'hA0 + 8'(i));
      chk("R5 tx_nearly_empty level", tx_nearly_empty, (i + 1 <= 2) ? 1 : 0);
      chk("R3 tx_empty after write", tx_empty, 0);
    end
    for (int i = 0; i < 5; i++) tx_pop_expect("R2 tx order", 8'hA0 + i);
    chk("R3 tx empty after drain", tx_empty, 1);
    eng_tx_pop = 1; @(negedge clk); eng_tx_pop = 0;
    tx_write(8'h31);
    chk("R11 pop on empty ignored", eng_tx_data, 8'h31);
    // push and pop in one cycle keep the count at one
    host_tx_wr = 1; host_tx_data = 8'h32; eng_tx_pop = 1;
    @(negedge clk);
    host_tx_wr = 0; eng_tx_pop = 0;
    chk("R3 simultaneous push pop tx_empty", tx_empty, 0);
    tx_pop_expect("R3 simultaneous push pop data", 8'h32);
    chk("R3 empty after last pop", tx_empty, 1);
  endtask

  task automatic t_clamp;
    tx_thresh = 15;
    rx_thresh = 12;
    for (int i = 1; i <= LIMIT + 1; i++) begin
      tx_write(8'(i));
      rx_push(8'(i));
      chk("R4 R5 tx clamp", tx_nearly_empty, (i <= LIMIT) ? 1 : 0);
      chk("R4 R6 rx clamp", rx_nearly_full, (i >= LIMIT) ? 1 : 0);
    end
    for (int i = 1; i <= LIMIT + 1; i++) begin
      tx_pop_expect("R2 tx drain", i);
      rx_read_expect("R2 rx drain", i);
    end
    chk("R6 rx empty not near", rx_nearly_full, 0);
  endtask

  task automatic t_overrun;
    for (int i = 0; i < DEPTH; i++) tx_write(8'h40 + 8'(i));
    chk("R3 tx_full at depth", tx_full, 1);
    chk("R7 no overrun yet", tx_overrun, 0);
    tx_write(8'hEE);
    chk("R7 overrun raised", tx_overrun, 1);
    chk("R7 still full", tx_full, 1);
    for (int i = 0; i < DEPTH; i++) tx_pop_expect("R7 dropped byte absent", 8'h40 + i);
    chk("R7 empty after drain", tx_empty, 1);
    chk("R7 overrun sticky", tx_overrun, 1);
  endtask

  task automatic t_rx_edges;
    rx_thresh = 3;
    rx_read_expect("R8 empty read zero", 0);
    chk("R8 still empty", rx_empty, 1);
    for (int i = 0; i < DEPTH; i++) rx_push(8'h60 + 8'(i));
    chk("R3 rx_full", rx_full, 1);
    rx_push(8'hDD);
    for (int i = 0; i < DEPTH; i++) rx_read_expect("R11 R2 rx order", 8'h60 + i);
    chk("R11 extra push dropped", rx_empty, 1);
    rx_read_expect("R8 empty read zero again", 0);
    rx_push(8'h77);
    rx_read_expect("R8 pointers unchanged", 8'h77);
  endtask

  task automatic t_flush_tx;
    for (int i = 0; i < 3; i++) tx_write(8'h10 + 8'(i));
    for (int i = 0; i < 4; i++) rx_push(8'h20 + 8'(i));
    flush_tx_set = 1;
    @(negedge clk);
    flush_tx_set = 0;
    for (int k = 1; k <= 4; k++) begin
      chk("R9 tx busy window", flush_tx_busy, 1);
      if (k == 1) begin host_tx_wr = 1; host_tx_data = 8'h55; end
      if (k == 2) flush_tx_set = 1;
      if (k == 3) eng_tx_pop = 1;
      @(negedge clk);
      host_tx_wr = 0; flush_tx_set = 0; eng_tx_pop = 0;
    end
    chk("R9 R10 tx busy clears after 4", flush_tx_busy, 0);
    chk("R9 R10 tx empty after flush", tx_empty, 1);
    chk("R9 tx head zero", eng_tx_data, 0);
    chk("R7 overrun cleared by flush", tx_overrun, 0);
    chk("R9 rx untouched", rx_empty, 0);
    rx_read_expect("R9 rx intact", 8'h20);
  endtask

  task automatic t_flush_rx;
    flush_rx_set = 1;
    @(negedge clk);
    flush_rx_set = 0;
    for (int k = 1; k <= 4; k++) begin
      chk("R9 rx busy window", flush_rx_busy, 1);
      if (k == 2) begin eng_rx_push = 1; eng_rx_data = 8'h99; end
      @(negedge clk);
      eng_rx_push = 0;
    end
    chk("R9 rx busy clears", flush_rx_busy, 0);
    chk("R10 rx empty after flush", rx_empty, 1);
    chk("R10 rx read zero", host_rx_data, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_tx_order();
    t_clamp();
    t_overrun();
    t_rx_edges();
    t_flush_tx();
    t_flush_rx();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule